// File: doc/BRIEF.md
# Shared Display-Bus Arbiter

This block sits between a processor bus and a display-memory bus that is also used by a DMA engine. Each processor bus cycle is classified by address. A cycle to the shared window (display memory and the custom register space) must win the shared bus before it is acknowledged. A cycle to a private device (boot ROM, I/O ports) is acknowledged after a fixed wait and never touches the shared-bus logic. The processor runs on a clock at twice the memory clock rate and synchronous to it. A shared cycle is therefore granted only on a processor edge that lines up with the memory clock. The `mem_phase` input marks that edge.

The arbiter drives three outputs. The first is the active-low data-transfer acknowledge. The second enables the drivers that join the processor bus to the shared bus. The third selects whether the memory address multiplexer takes the processor address or the DMA engine's address register. While the DMA engine holds its request, the shared bus stays isolated from the processor. Private processor cycles can complete during this time in parallel. DRAM timing, refresh and the DMA engine itself live elsewhere.

Top module: `shared_bus_arbiter`

## Requirements
- R1: An address from SHARED_LO up to SHARED_HI inclusive (defaults 24'h080000 and 24'hDFFFFF) is a shared cycle. Every other address is a private cycle.
- R2: A private cycle drives `cpu_dtack_n` low after the PRIV_WAIT-th rising edge (default 3) that samples `cpu_as_n` low. This holds whatever `dma_req_n` does, and `bus_drv_en` stays 0 throughout.
- R3: After a rising edge that samples `cpu_as_n` high, `cpu_dtack_n` is 1 and `bus_drv_en` is 0.
- R4: A shared cycle is granted only at a rising edge that samples `cpu_as_n` low, `dma_req_n` high and `mem_phase` high. After that edge `cpu_dtack_n` is 0 and `bus_drv_en` is 1.
- R5: While the DMA engine owns the bus, `amux_cpu_sel` is 0, `bus_drv_en` is 0 and a pending shared cycle keeps `cpu_dtack_n` high.
- R6: If the same edge samples a shared processor request and `dma_req_n` low with the bus free, the DMA engine gets the bus.
- R7: A granted processor cycle is not preempted. A DMA request that arrives mid-cycle leaves the acknowledge low until `cpu_as_n` is released. The DMA engine takes the bus at the release edge.
- R8: `amux_cpu_sel` is 1 exactly when the processor owns the shared bus, so it equals `bus_drv_en`.
- R9: After reset `cpu_dtack_n` is 1, `bus_drv_en` is 0 and `amux_cpu_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock, twice the memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_as_n | input | 1 | Processor address strobe, active low |
| cpu_addr | input | AW | Processor address |
| dma_req_n | input | 1 | DMA bus request, active low |
| mem_phase | input | 1 | High on the processor edge aligned with the memory clock |
| cpu_dtack_n | output | 1 | Data-transfer acknowledge, active low |
| bus_drv_en | output | 1 | Enable for the processor-to-shared-bus drivers |
| amux_cpu_sel | output | 1 | Address mux select: 1 processor address, 0 DMA address |

## Verification
The assertions check these rules on every cycle: a shared grant only happens on an aligned edge with no DMA request; the DMA engine wins a tie on a free bus; a granted cycle holds the bus until its strobe drops; releasing the strobe drops both acknowledge and driver enable; and a private cycle never turns the drivers on. Some behaviour can only be shown by the bench's scenarios. This covers the exact wait length of private cycles and the decode at both window boundaries. It also covers the mux select following ownership, and a private cycle completing while DMA holds the bus. The bench shows these by comparing every output with its own model each cycle.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_DMA  = 2'd1,
    OWN_CPU  = 2'd2
  } owner_e;
endpackage

// File: rtl/sba_decode.sv
module sba_decode #(
  parameter int AW = 24,
  parameter logic [AW-1:0] SHARED_LO = 24'h080000,
  parameter logic [AW-1:0] SHARED_HI = 24'hDFFFFF
) (
  input  logic [AW-1:0] addr,
  output logic          is_shared
);
  // R1: inclusive window compare
  always_comb begin
    is_shared = (addr >= SHARED_LO) && (addr <= SHARED_HI);
  end
endmodule

// File: rtl/sba_priv_wait.sv
module sba_priv_wait #(
  parameter int PRIV_WAIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic clr,
  output logic ack
);
  localparam int CW = $clog2(PRIV_WAIT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PRIV_WAIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr || (req && (cnt_q != LIMIT));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ack = (cnt_q == LIMIT);

  assert_priv_ack_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !$past(ack)) |-> ($past(req) && !$past(clr)));
endmodule

// File: rtl/sba_owner.sv
module sba_owner
  import sba_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cyc,
  input  logic   shared,
  input  logic   dma_req_n,
  input  logic   mem_phase,
  output owner_e own
);
  owner_e own_q, own_d;
  logic   cpu_bid;

  always_comb begin
    cpu_bid = cyc && shared && mem_phase;
    own_d   = own_q;
    unique case (own_q)
      OWN_CPU: begin
        if (!cyc) own_d = dma_req_n ? OWN_IDLE : OWN_DMA;
      end
      default: begin
        if (!dma_req_n)   own_d = OWN_DMA;
        else if (cpu_bid) own_d = OWN_CPU;
        else              own_d = OWN_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_IDLE;
    else        own_q <= own_d;
  end

  assign own = own_q;

  assert_grant_aligned_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_CPU && $past(own_q) != OWN_CPU) |-> ($past(dma_req_n) && $past(mem_phase)));

  assert_dma_wins_tie_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req_n && own_q != OWN_CPU) |=> (own_q == OWN_DMA));

  assert_no_preempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_CPU && cyc) |=> (own_q == OWN_CPU));
endmodule

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter
  import sba_pkg::*;
#(
  parameter int AW = 24,
  parameter logic [AW-1:0] SHARED_LO = 24'h080000,
  parameter logic [AW-1:0] SHARED_HI = 24'hDFFFFF,
  parameter int PRIV_WAIT = 3,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_as_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          dma_req_n,
  input  logic          mem_phase,
  output logic          cpu_dtack_n,
  output logic          bus_drv_en,
  output logic          amux_cpu_sel
);
  // asynchronous assert, synchronous release
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  logic   is_shared, cyc, priv_ack;
  owner_e own;

  assign cyc = !cpu_as_n;

  sba_decode #(.AW(AW), .SHARED_LO(SHARED_LO), .SHARED_HI(SHARED_HI)) u_decode (
    .addr      (cpu_addr),
    .is_shared (is_shared)
  );

  sba_priv_wait #(.PRIV_WAIT(PRIV_WAIT)) u_priv (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req   (cyc && !is_shared),
    .clr   (!cyc),
    .ack   (priv_ack)
  );

  sba_owner u_owner (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cyc       (cyc),
    .shared    (is_shared),
    .dma_req_n (dma_req_n),
    .mem_phase (mem_phase),
    .own       (own)
  );

  always_comb begin
    bus_drv_en   = (own == OWN_CPU);
    amux_cpu_sel = (own == OWN_CPU);
    cpu_dtack_n  = !(priv_ack || (own == OWN_CPU));
  end

  assert_release_drops_ack_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_as_n |=> (cpu_dtack_n && !bus_drv_en));

  assert_private_isolated_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cyc && !is_shared) |-> !bus_drv_en);

  assert_dma_blocks_ack_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (own == OWN_DMA) |-> (!amux_cpu_sel && !bus_drv_en));
endmodule

// File: tb/shared_bus_arbiter_test.sv
`timescale 1ns/1ps
module shared_bus_arbiter_test;
  localparam int AW = 24;
  localparam logic [AW-1:0] SH_LO = 24'h080000;
  localparam logic [AW-1:0] SH_HI = 24'hDFFFFF;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_as_n, dma_req_n, mem_phase;
  logic [AW-1:0] cpu_addr;
  logic cpu_dtack_n, bus_drv_en, amux_cpu_sel;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  shared_bus_arbiter uut (
    .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_addr(cpu_addr),
    .dma_req_n(dma_req_n), .mem_phase(mem_phase),
    .cpu_dtack_n(cpu_dtack_n), .bus_drv_en(bus_drv_en), .amux_cpu_sel(amux_cpu_sel)
  );

  function automatic bit in_window(logic [AW-1:0] a);
    return (a >= SH_LO) && (a <= SH_HI);
  endfunction

  // reference model: 0 free, 1 DMA, 2 CPU
  int m_own;
  int m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_own = 0;
      m_cnt = 0;
    end else begin
      if (cpu_as_n) m_cnt = 0;
      else if (!in_window(cpu_addr) && m_cnt < PW) m_cnt = m_cnt + 1;
      if (m_own == 2) begin
        if (cpu_as_n) m_own = dma_req_n ? 0 : 1;
      end else if (!dma_req_n) m_own = 1;
      else if (!cpu_as_n && in_window(cpu_addr) && mem_phase) m_own = 2;
      else m_own = 0;
    end
  end

  function automatic logic exp_dtack_n();
    return !((m_cnt == PW) || (m_own == 2));
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick(string dtag);
    @(negedge clk);
    chk(dtag, "cpu_dtack_n", cpu_dtack_n, exp_dtack_n());
    chk("R3", "bus_drv_en", bus_drv_en, m_own == 2);
    chk("R5", "amux_cpu_sel", amux_cpu_sel, m_own == 2);
    chk("R8", "amux equals drv_en", amux_cpu_sel, bus_drv_en);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit busy;
    int dhold;
    process::self().srandom(32'd1234);
    rst_n = 1'b0; cpu_as_n = 1'b1; dma_req_n = 1'b1; mem_phase = 1'b0; cpu_addr = '0;
    repeat (3) @(negedge clk);
    chk("R9", "reset dtack", cpu_dtack_n, 1'b1);
    chk("R9", "reset drv", bus_drv_en, 1'b0);
    chk("R9", "reset amux", amux_cpu_sel, 1'b0);
    rst_n = 1'b1;
    repeat (4) tick("R9");

    // R4: wrong phase waits one edge
    cpu_addr = SH_LO; cpu_as_n = 1'b0; mem_phase = 1'b0;
    tick("R4");
    chk("R4", "stall off-phase", cpu_dtack_n, 1'b1);
    mem_phase = 1'b1;
    tick("R4");
    chk("R4", "grant on phase", cpu_dtack_n, 1'b0);
    // R7: DMA request mid-cycle does not preempt
    dma_req_n = 1'b0; mem_phase = 1'b0;
    tick("R7"); tick("R7");
    chk("R7", "ack held under DMA req", cpu_dtack_n, 1'b0);
    cpu_as_n = 1'b1;
    tick("R3");
    chk("R3", "release dtack", cpu_dtack_n, 1'b1);
    chk("R7", "DMA takes bus at release", amux_cpu_sel, 1'b0);
    // R1 + R2: SH_HI is shared (stalls under DMA), SH_HI+1 private (acks)
    cpu_addr = SH_HI; cpu_as_n = 1'b0; mem_phase = 1'b1;
    repeat (4) tick("R5");
    chk("R1", "SH_HI stalls under DMA", cpu_dtack_n, 1'b1);
    cpu_as_n = 1'b1; tick("R3");
    cpu_addr = SH_HI + 1'b1; cpu_as_n = 1'b0;
    tick("R2"); tick("R2");
    chk("R2", "private not yet acked", cpu_dtack_n, 1'b1);
    tick("R2");
    chk("R1", "SH_HI+1 private ack under DMA", cpu_dtack_n, 1'b0);
    chk("R2", "private no drivers", bus_drv_en, 1'b0);
    cpu_as_n = 1'b1; tick("R3");
    cpu_addr = SH_LO - 1'b1; cpu_as_n = 1'b0;
    repeat (3) tick("R2");
    chk("R1", "SH_LO-1 private", cpu_dtack_n, 1'b0);
    cpu_as_n = 1'b1; dma_req_n = 1'b1; tick("R3"); tick("R3");
    // R6: tie on free bus
    cpu_addr = SH_LO + 24'h100; cpu_as_n = 1'b0; dma_req_n = 1'b0; mem_phase = 1'b1;
    tick("R6");
    chk("R6", "DMA wins tie", bus_drv_en, 1'b0);
    chk("R6", "no ack on tie", cpu_dtack_n, 1'b1);
    dma_req_n = 1'b1; mem_phase = 1'b0; tick("R6");
    mem_phase = 1'b1; tick("R6");
    chk("R6", "CPU served after DMA", cpu_dtack_n, 1'b0);
    cpu_as_n = 1'b1; tick("R3");

    // random phase
    busy = 1'b0; dhold = 0;
    for (int i = 0; i < 4000; i++) begin
      mem_phase = ~mem_phase;
      if (dhold == 0) begin
        dma_req_n = ($urandom % 3) != 0;
        dhold = 1 + $urandom % 6;
      end else dhold--;
      if (!busy) begin
        if ($urandom % 2) begin
          case ($urandom % 6)
            0: cpu_addr = SH_LO;
            1: cpu_addr = SH_HI;
            2: cpu_addr = SH_LO - 1'b1;
            3: cpu_addr = SH_HI + 1'b1;
            4: cpu_addr = SH_LO + AW'($urandom % 32'h10000);
            default: cpu_addr = AW'($urandom);
          endcase
          cpu_as_n = 1'b0; busy = 1'b1;
        end
      end else if (!cpu_dtack_n) begin
        cpu_as_n = 1'b1; busy = 1'b0;
      end
      tick(in_window(cpu_addr) ? "R4" : "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule